// File: doc/BRIEF.md
# I2C Register Target with Packet Error Checking

This block is an I2C target that exposes a small register file to an external host. A STARTed transfer begins with an address byte. If that byte carries the block's 7-bit device address, the block acknowledges it. In a write, the next byte loads an internal register pointer, and the bytes after it are stored at consecutive registers. In a read, the block shifts out bytes starting at the current pointer. The rest of the chip reads and writes the same registers through a plain parallel port.

The device address comes from a configuration input, so it is not fixed. A configuration bit can make an external pin supply the lowest address bit, which lets two identical devices share one bus. A second configuration bit turns on packet error checking (PEC). When PEC is on, a write is held until a trailing CRC-8 byte confirms it, and a read ends with a CRC-8 byte that the block computes.

NREG must be a power of two.

Top module: `i2c_pec_regslave`

## Requirements
- R1: The block acknowledges an address byte only when bits 7..1 equal the effective device address. For any other address it never pulls SDA low, and it ignores the rest of the transfer.
- R2: When `cfg_lsb_pin_en` is 1, the effective address is `cfg_addr[6:1]` followed by the level of `addr_lsb_pin`. When it is 0, the effective address is `cfg_addr`.
- R3: A write (address byte bit 0 = 0) takes its second byte as the register pointer, using its low log2(NREG) bits. With PEC off, every later byte is acknowledged and written to the pointed register, and the pointer then increments, wrapping at NREG.
- R4: A read (address byte bit 0 = 1) sends the register at the pointer, MSB first, and increments the pointer. It keeps sending while the host acknowledges and stops at a host NACK. A read after a repeated START starts at the current pointer.
- R5: With PEC on, a write consists of the address, the pointer, one data byte and a CRC byte. The data byte is committed, and the pointer incremented, only if the CRC byte matches. On a mismatch the CRC byte is NACKed and the register keeps its value.
- R6: With PEC on, a read returns one data byte and then, if the host acknowledges it, the CRC byte.
- R7: The CRC is CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first. It covers every byte of the transaction, including the write part and the address byte sent again after a repeated START. It is cleared at STOP and at a START outside an addressed transaction.
- R8: A START at any bit position restarts address reception. A STOP returns the block to idle and discards held PEC write data.
- R9: SDA is open drain. `sda_oe` = 1 pulls the line low, and `sda_oe` changes only while SCL is low. ACK is driven during the ninth clock of a byte.
- R10: `core_rdata` shows the register at `core_raddr` combinationally. `core_we` writes `core_wdata` into the register at `core_waddr` on the next clock.
- R11: After reset, all registers and the pointer are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_addr | input | 7 | Configured device address |
| cfg_lsb_pin_en | input | 1 | Take address bit 0 from the pin |
| addr_lsb_pin | input | 1 | External address LSB |
| cfg_pec_en | input | 1 | Enable packet error checking |
| core_raddr | input | log2(NREG) | Chip-side read index |
| core_rdata | output | 8 | Chip-side read data |
| core_we | input | 1 | Chip-side write strobe |
| core_waddr | input | log2(NREG) | Chip-side write index |
| core_wdata | input | 8 | Chip-side write data |

## Verification
The assertions check on every cycle the bus-level rules that hold for every transfer:
- `sda_oe` is asserted only while SCL is low.
- SDA stays released while the block is idle.
- A START sends the block back to address reception, and a STOP sends it to idle with the CRC cleared.
- Every committed write advances the pointer.

Only the bench's scenarios can show the behaviours that depend on values:
- which addresses get an ACK, including the pin-selected LSB;
- pointer wrap-around and reads that continue from the current pointer;
- the CRC value sent after a read;
- a corrupted CRC byte leaving the register unchanged;
- a STOP discarding held data.

// File: rtl/i2c_pec_regslave.sv
module i2c_pec_regslave #(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [6:0]    cfg_addr,
  input  logic          cfg_lsb_pin_en,
  input  logic          addr_lsb_pin,
  input  logic          cfg_pec_en,
  input  logic [AW-1:0] core_raddr,
  output logic [7:0]    core_rdata,
  input  logic          core_we,
  input  logic [AW-1:0] core_waddr,
  input  logic [7:0]    core_wdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} st_t;
  typedef enum logic [1:0] {RL_ADDR, RL_PTR, RL_DATA} rl_t;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  logic [6:0] dev_addr;
  assign dev_addr = {cfg_addr[6:1], cfg_lsb_pin_en ? addr_lsb_pin : cfg_addr[0]};

  st_t          st;
  rl_t          role;
  logic [3:0]   cnt;
  logic [6:0]   shreg;
  logic [7:0]   txb, crc, hold;
  logic [AW-1:0] ptr;
  logic         held, pec_sent, ack_q, go_q, tx_q, mack, active;
  logic [7:0]   regs [NREG];

  logic       byte_in, i2c_we;
  logic [7:0] rx_byte, i2c_wd, tx_next;
  assign rx_byte = {shreg, sda_s};
  assign byte_in = (st == ST_RX) && scl_rise && (cnt == 4'd7);
  assign i2c_we  = byte_in && (role == RL_DATA) && (!cfg_pec_en || (held && rx_byte == crc));
  assign i2c_wd  = cfg_pec_en ? hold : rx_byte;
  assign tx_next = regs[ptr];
  assign core_rdata = regs[core_raddr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else begin
      if (core_we) regs[core_waddr] <= core_wdata;
      if (i2c_we)  regs[ptr] <= i2c_wd;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE;  role <= RL_ADDR;  cnt <= 4'd0;  shreg <= 7'd0;
      txb <= 8'd0;  crc <= 8'd0;  hold <= 8'd0;  ptr <= '0;
      held <= 1'b0;  pec_sent <= 1'b0;  ack_q <= 1'b0;  go_q <= 1'b0;
      tx_q <= 1'b0;  mack <= 1'b0;  active <= 1'b0;  sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE;  active <= 1'b0;  crc <= 8'd0;  sda_oe <= 1'b0;  held <= 1'b0;
    end else if (start_det) begin
      st <= ST_RX;  role <= RL_ADDR;  cnt <= 4'd0;  sda_oe <= 1'b0;  held <= 1'b0;
      if (!active) crc <= 8'd0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            if (cnt < 4'd8) begin
              shreg <= rx_byte[6:0];
              cnt   <= cnt + 4'd1;
            end else if (cnt == 4'd9) begin
              cnt <= 4'd10;
            end
            if (byte_in) begin
              case (role)
                RL_ADDR: begin
                  if (rx_byte[7:1] == dev_addr) begin
                    ack_q <= 1'b1;  go_q <= 1'b1;  active <= 1'b1;
                    tx_q  <= rx_byte[0];
                    crc   <= crc_step(crc, rx_byte);
                    role  <= RL_PTR;
                  end else begin
                    ack_q <= 1'b0;  go_q <= 1'b0;
                  end
                end
                RL_PTR: begin
                  ptr  <= rx_byte[AW-1:0];
                  crc  <= crc_step(crc, rx_byte);
                  ack_q <= 1'b1;  go_q <= 1'b1;  tx_q <= 1'b0;
                  held <= 1'b0;
                  role <= RL_DATA;
                end
                default: begin
                  tx_q <= 1'b0;
                  if (!cfg_pec_en) begin
                    ptr <= ptr + 1'b1;
                    crc <= crc_step(crc, rx_byte);
                    ack_q <= 1'b1;  go_q <= 1'b1;
                  end else if (!held) begin
                    hold <= rx_byte;  held <= 1'b1;
                    crc  <= crc_step(crc, rx_byte);
                    ack_q <= 1'b1;  go_q <= 1'b1;
                  end else begin
                    held  <= 1'b0;  go_q <= 1'b0;
                    ack_q <= (rx_byte == crc);
                    if (rx_byte == crc) ptr <= ptr + 1'b1;
                  end
                end
              endcase
            end
          end
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= ack_q;
              cnt    <= 4'd9;
            end else if (cnt == 4'd10) begin
              cnt <= 4'd0;
              if (!go_q) begin
                st <= ST_IDLE;  sda_oe <= 1'b0;
              end else if (tx_q) begin
                st <= ST_TX;
                txb <= tx_next;  sda_oe <= ~tx_next[7];
                ptr <= ptr + 1'b1;  pec_sent <= 1'b0;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            if (cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7 && !pec_sent) crc <= crc_step(crc, txb);
            end else if (cnt == 4'd9) begin
              mack <= ~sda_s;
              cnt  <= 4'd10;
            end
          end
          if (scl_fall) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sda_oe <= ~txb[3'd7 - cnt[2:0]];
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd9;
            end else if (cnt == 4'd10) begin
              cnt <= 4'd0;
              if (!mack || pec_sent) begin
                st <= ST_IDLE;  sda_oe <= 1'b0;
              end else if (cfg_pec_en) begin
                txb <= crc;  sda_oe <= ~crc[7];  pec_sent <= 1'b1;
              end else begin
                txb <= tx_next;  sda_oe <= ~tx_next[7];
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end

  p_oe_on_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  p_start_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_RX && role == RL_ADDR && cnt == 4'd0));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && crc == 8'h00 && !sda_oe));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_we |=> (ptr == $past(ptr) + 1'b1));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd10);

endmodule

// File: tb/i2c_pec_regslave_bench.sv
module i2c_pec_regslave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NREG = 16;
  localparam int AW = 4;
  localparam logic [6:0] DEV = 7'h10;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, sda_line;
  logic [6:0] cfg_addr = DEV;
  logic lsb_en = 0, lsb_pin = 0, pec_en = 0;
  logic [AW-1:0] core_raddr = '0, core_waddr = '0;
  logic [7:0] core_rdata, core_wdata = 8'h00;
  logic core_we = 0;

  assign sda_line = sda_m & ~sda_oe;

  i2c_pec_regslave #(.NREG(NREG)) u_i2c_pec_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_addr(cfg_addr), .cfg_lsb_pin_en(lsb_en), .addr_lsb_pin(lsb_pin),
    .cfg_pec_en(pec_en), .core_raddr(core_raddr), .core_rdata(core_rdata),
    .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, viol = 0, cyc = 0;
  bit done = 0;
  logic [7:0] mdl [NREG];
  logic [AW-1:0] mptr = '0;
  logic [7:0] wbuf [4];
  logic oe_prev = 0;

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic i_start();
    sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq();
  endtask

  task automatic i_stop();
    sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; hq(); scl_m = 1; hq(); b = sda_line; hq(); scl_m = 0; hq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic get_byte(input logic ackit, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(~ackit);
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++) begin
      core_raddr = AW'(i);
      #1;
      check(req, core_rdata, mdl[i]);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n,
                          input bit pec, input bit corrupt, input string req);
    logic ack;
    logic [7:0] c = 8'h00;
    pec_en = pec;
    i_start();
    put_byte({a, 1'b0}, ack); check(req, ack, 1); c = bcrc(c, {a, 1'b0});
    put_byte(p, ack); check(req, ack, 1); c = bcrc(c, p);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], ack); check(req, ack, 1); c = bcrc(c, wbuf[i]);
    end
    if (pec) begin
      put_byte(corrupt ? ~c : c, ack);
      check(req, ack, corrupt ? 0 : 1);
    end
    i_stop();
    mptr = p[AW-1:0];
    if (!(pec && corrupt))
      for (int i = 0; i < n; i++) begin mdl[mptr] = wbuf[i]; mptr = mptr + 1'b1; end
  endtask

  task automatic do_read(input int n, input bit pec, input bit with_ptr,
                         input logic [7:0] p, input string req);
    logic ack;
    logic [7:0] b;
    logic [7:0] c = 8'h00;
    pec_en = pec;
    i_start();
    if (with_ptr) begin
      put_byte({DEV, 1'b0}, ack); check(req, ack, 1); c = bcrc(c, {DEV, 1'b0});
      put_byte(p, ack); check(req, ack, 1); c = bcrc(c, p);
      mptr = p[AW-1:0];
      i_start();
    end
    put_byte({DEV, 1'b1}, ack); check(req, ack, 1); c = bcrc(c, {DEV, 1'b1});
    for (int i = 0; i < n; i++) begin
      get_byte((i < n - 1) || pec, b);
      check(req, b, mdl[mptr]);
      c = bcrc(c, b);
      mptr = mptr + 1'b1;
    end
    if (pec) begin
      get_byte(1'b0, b);
      check(req, b, c);
    end
    i_stop();
  endtask

  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) viol++;
    oe_prev = sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    check("R11 sda released in reset", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_regs("R11 regs zero");
    do_read(1, 0, 0, 8'h00, "R11 pointer zero");

    for (int i = 0; i < NREG; i++) begin
      core_we = 1; core_waddr = AW'(i); core_wdata = 8'(i * 17 + 3);
      mdl[i] = 8'(i * 17 + 3);
      @(negedge clk);
    end
    core_we = 0;
    chk_regs("R10 core port");

    i_start();
    put_byte({7'h11, 1'b0}, ack); check("R1 wrong address nack", ack, 0);
    put_byte(8'h05, ack); check("R1 ignored byte", ack, 0);
    put_byte(8'hEE, ack); check("R1 ignored byte", ack, 0);
    i_stop();
    chk_regs("R1 regs untouched");

    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(DEV, 8'h0E, 3, 0, 0, "R3 write wrap");
    chk_regs("R3 regs after write");
    do_read(4, 0, 1, 8'h0D, "R4 read with pointer");
    do_read(2, 0, 0, 8'h00, "R4 read from current pointer");

    lsb_en = 1; lsb_pin = 1;
    wbuf[0] = 8'h5A;
    do_write(7'h11, 8'h02, 1, 0, 0, "R2 pin lsb high");
    i_start(); put_byte({DEV, 1'b0}, ack); i_stop();
    check("R2 stored lsb ignored", ack, 0);
    lsb_pin = 0;
    i_start(); put_byte({7'h11, 1'b0}, ack); i_stop();
    check("R2 pin lsb low rejects 11", ack, 0);
    wbuf[0] = 8'h6B;
    do_write(DEV, 8'h03, 1, 0, 0, "R2 pin lsb low");
    lsb_en = 0;
    chk_regs("R2 regs");

    wbuf[0] = 8'h3C;
    do_write(DEV, 8'h05, 1, 1, 0, "R5 pec write good");
    chk_regs("R5 committed");
    wbuf[0] = 8'hFF;
    do_write(DEV, 8'h06, 1, 1, 1, "R5 pec write bad");
    chk_regs("R5 discarded");
    do_read(1, 1, 1, 8'h05, "R6 R7 pec read after rep start");
    do_read(1, 1, 0, 8'h00, "R6 R7 pec read plain");

    pec_en = 1;
    i_start();
    put_byte({DEV, 1'b0}, ack); put_byte(8'h07, ack); put_byte(8'h99, ack);
    i_stop();
    mptr = 4'h7;
    chk_regs("R8 stop discards held");
    pec_en = 0;
    i_start();
    put_byte({DEV, 1'b0}, ack);
    put_bit(1); put_bit(0); put_bit(1);
    wbuf[0] = 8'h77;
    do_write(DEV, 8'h08, 1, 0, 0, "R8 start mid byte");
    chk_regs("R8 regs after restart");

    for (int k = 0; k < 30; k++) begin
      bit pec, corrupt, wr, wp;
      int n;
      logic [7:0] p;
      pec = ($urandom % 2) == 1;
      wr = ($urandom % 2) == 1;
      n = pec ? 1 : 1 + int'($urandom % 4);
      p = 8'($urandom);
      if (wr) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        corrupt = pec && (($urandom % 4) == 0);
        do_write(DEV, p, n, pec, corrupt, pec ? "R5 random" : "R3 random");
      end else begin
        wp = ($urandom % 2) == 1;
        do_read(n, pec, wp, p, pec ? "R6 random" : "R4 random");
      end
    end
    chk_regs("R3 R5 final regs");

    check("R9 sda changed with scl high", viol, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule